// File: doc/BRIEF.md
# Cache-Block Zeroing Engine

This engine carries out a block-zero request for a processor pipeline. On a start strobe it takes the register address and aligns it down to a power-of-two block. It asks an external translation unit for a store-type translation of that block base. It then writes zero words across the whole physical block through a simple memory write port, one 32-bit word per beat.

The block size is two to the power of a per-request exponent. The exponent is held between a one-word minimum and a parameterised maximum. A beat advances only when the memory accepts it. A translation fault or a memory write error aborts the request, and the aligned virtual base is reported with a cause code. A request made while zeroing is not enabled for the current privilege is refused with its own cause, and it touches neither translation nor memory. The engine raises a single-cycle done or fault pulse and then returns to idle.

Top module: `blkz_engine`

## Requirements
- R1: After reset the engine is idle: `xlatReq`, `memWrEn`, `done` and `fault` are 0, and `faultCause` is 0.
- R2: An accepted start puts the start address with its low E bits cleared on `xlatVaddr`, where E is the effective exponent. `xlatReq` is then held high with a stable `xlatVaddr` until `xlatRespValid` is seen.
- R3: After a clean translation the engine writes 2^(E-2) words. Every `memData` is zero. The addresses begin at the physical base (the returned `xlatPaddr` with its low E bits cleared) and rise by 4 per beat. Address and enable hold while `memReady` is low.
- R4: The cycle after the last beat is accepted, `done` is high for exactly one cycle and `fault` stays low.
- R5: A translation response with `xlatFault` set gives a one-cycle `fault` with `faultCause` = 2 and `faultAddr` = aligned virtual base. No write is issued.
- R6: A beat accepted with `memErr` high aborts the request. This holds on the last beat too. The next cycle gives `fault` with `faultCause` = 3 and `faultAddr` = aligned virtual base. No further write is issued and `done` is not raised.
- R7: A start while `zeroEnable` is 0 gives a one-cycle `fault` with `faultCause` = 1 the next cycle. There is no translation request and no write.
- R8: A start strobe is ignored while a request is in progress, including the cycle in which `done` or `fault` is high.
- R9: An exponent below 2 is treated as 2. An exponent above MAX_EXP (default 8) is treated as MAX_EXP.
- R10: `done` and `fault` are never high in the same cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, sampled while idle |
| startAddr | input | ADDR_W | Register address of the request |
| blkExp | input | EXP_W | Block size exponent |
| zeroEnable | input | 1 | Zeroing permitted at current privilege |
| xlatReq | output | 1 | Store-type translation request |
| xlatVaddr | output | ADDR_W | Aligned virtual block base |
| xlatRespValid | input | 1 | Translation response strobe |
| xlatFault | input | 1 | Translation refused |
| xlatPaddr | input | ADDR_W | Translated physical address |
| memWrEn | output | 1 | Write beat valid |
| memAddr | output | ADDR_W | Word write address |
| memData | output | 32 | Write data (always zero) |
| memReady | input | 1 | Memory accepts the beat |
| memErr | input | 1 | Accepted beat failed |
| done | output | 1 | Completion pulse |
| fault | output | 1 | Abort pulse |
| faultCause | output | 2 | 1 disabled, 2 translation, 3 memory; 0 when no fault |
| faultAddr | output | ADDR_W | Aligned virtual base during fault, else 0 |

## Verification
Two pairs of events can land in one cycle. The first is a new start strobe and the completion pulse. The bench raises `start` exactly in the cycle it sees `done` high, then confirms that no second translation request follows. The second is acceptance of the final beat together with a memory error. The bench arms the error on the last word and expects a memory fault, the full count of words minus one accepted, and no `done` pulse.

// File: rtl/blkz_pkg.sv
package blkz_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_XLAT, ST_WRITE, ST_DONE, ST_FAULT
  } blkz_state_t;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_DISABLED = 2'd1,
    CAUSE_XLAT     = 2'd2,
    CAUSE_MEM      = 2'd3
  } blkz_cause_t;

  typedef struct packed {
    logic loadReq;
    logic loadPhys;
    logic stepBeat;
  } blkz_ctl_t;
endpackage

// File: rtl/blkz_datapath.sv
module blkz_datapath
  import blkz_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  blkz_ctl_t         ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [EXP_W-1:0]  blkExp,
  input  logic [ADDR_W-1:0] xlatPaddr,
  output logic [ADDR_W-1:0] virtBase,
  output logic [ADDR_W-1:0] memAddr,
  output logic              lastBeat
);
  localparam int MIN_EXP = 2;
  localparam int IDX_W   = MAX_EXP - MIN_EXP + 1;

  logic [EXP_W-1:0]  effExp;
  logic [ADDR_W-1:0] newMask;
  logic [ADDR_W-1:0] maskReg;
  logic [ADDR_W-1:0] physBase;
  logic [IDX_W-1:0]  beatIdx;
  logic [IDX_W-1:0]  beatLast;

  always_comb begin
    if (blkExp < EXP_W'(MIN_EXP))      effExp = EXP_W'(MIN_EXP);
    else if (blkExp > EXP_W'(MAX_EXP)) effExp = EXP_W'(MAX_EXP);
    else                               effExp = blkExp;
    newMask = ~((ADDR_W'(1) << effExp) - ADDR_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      virtBase <= '0;
      maskReg  <= '0;
      physBase <= '0;
      beatIdx  <= '0;
      beatLast <= '0;
    end else begin
      if (ctl.loadReq) begin
        virtBase <= startAddr & newMask;
        maskReg  <= newMask;
        beatIdx  <= '0;
        beatLast <= (IDX_W'(1) << (effExp - EXP_W'(MIN_EXP))) - IDX_W'(1);
      end
      if (ctl.loadPhys) physBase <= xlatPaddr & maskReg;
      if (ctl.stepBeat) beatIdx <= beatIdx + IDX_W'(1);
    end
  end

  assign memAddr  = physBase | ADDR_W'({beatIdx, 2'b00});
  assign lastBeat = (beatIdx == beatLast);
endmodule

// File: rtl/blkz_control.sv
module blkz_control
  import blkz_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        zeroEnable,
  input  logic        xlatRespValid,
  input  logic        xlatFault,
  input  logic        memReady,
  input  logic        memErr,
  input  logic        lastBeat,
  output blkz_ctl_t   ctl,
  output logic        xlatReq,
  output logic        memWrEn,
  output logic        done,
  output logic        fault,
  output logic [1:0]  faultCause
);
  blkz_state_t state, stateNext;
  blkz_cause_t causeReg, causeNext;

  always_comb begin
    stateNext = state;
    causeNext = causeReg;
    ctl       = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.loadReq = 1'b1;
        if (zeroEnable) stateNext = ST_XLAT;
        else begin
          stateNext = ST_FAULT;
          causeNext = CAUSE_DISABLED;
        end
      end
      ST_XLAT: if (xlatRespValid) begin
        if (xlatFault) begin
          stateNext = ST_FAULT;
          causeNext = CAUSE_XLAT;
        end else begin
          ctl.loadPhys = 1'b1;
          stateNext    = ST_WRITE;
        end
      end
      ST_WRITE: if (memReady) begin
        if (memErr) begin
          stateNext = ST_FAULT;
          causeNext = CAUSE_MEM;
        end else if (lastBeat) stateNext = ST_DONE;
        else ctl.stepBeat = 1'b1;
      end
      ST_DONE:  stateNext = ST_IDLE;
      ST_FAULT: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      causeReg <= CAUSE_NONE;
    end else begin
      state    <= stateNext;
      causeReg <= causeNext;
    end
  end

  assign xlatReq    = (state == ST_XLAT);
  assign memWrEn    = (state == ST_WRITE);
  assign done       = (state == ST_DONE);
  assign fault      = (state == ST_FAULT);
  assign faultCause = fault ? causeReg : CAUSE_NONE;
endmodule

// File: rtl/blkz_engine.sv
module blkz_engine
  import blkz_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int EXP_W   = 4,
  parameter int MAX_EXP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [EXP_W-1:0]  blkExp,
  input  logic              zeroEnable,
  output logic              xlatReq,
  output logic [ADDR_W-1:0] xlatVaddr,
  input  logic              xlatRespValid,
  input  logic              xlatFault,
  input  logic [ADDR_W-1:0] xlatPaddr,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  input  logic              memReady,
  input  logic              memErr,
  output logic              done,
  output logic              fault,
  output logic [1:0]        faultCause,
  output logic [ADDR_W-1:0] faultAddr
);
  blkz_ctl_t         ctl;
  logic              lastBeat;
  logic [ADDR_W-1:0] virtBase;

  blkz_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .zeroEnable(zeroEnable),
    .xlatRespValid(xlatRespValid), .xlatFault(xlatFault),
    .memReady(memReady), .memErr(memErr), .lastBeat(lastBeat),
    .ctl(ctl), .xlatReq(xlatReq), .memWrEn(memWrEn),
    .done(done), .fault(fault), .faultCause(faultCause)
  );

  blkz_datapath #(.ADDR_W(ADDR_W), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .startAddr(startAddr),
    .blkExp(blkExp), .xlatPaddr(xlatPaddr), .virtBase(virtBase),
    .memAddr(memAddr), .lastBeat(lastBeat)
  );

  assign xlatVaddr = virtBase;
  assign memData   = '0;
  assign faultAddr = fault ? virtBase : '0;
endmodule

// File: rtl/blkz_checker.sv
module blkz_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xlatReq,
  input logic [ADDR_W-1:0] xlatVaddr,
  input logic              xlatRespValid,
  input logic              xlatFault,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memReady,
  input logic              memErr,
  input logic              done,
  input logic              fault
);
  p_xlat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xlatReq && !xlatRespValid |=> xlatReq && $stable(xlatVaddr));

  p_write_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    memWrEn && !memReady |=> memWrEn && $stable(memAddr));

  p_word_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    memWrEn && memReady && !memErr |=> done || (memAddr == $past(memAddr) + ADDR_W'(4)));

  p_xlat_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xlatReq && xlatRespValid && xlatFault |=> fault && !memWrEn);

  p_mem_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    memWrEn && memReady && memErr |=> fault && !memWrEn && !done);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fault_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
endmodule

bind blkz_engine blkz_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .xlatReq(xlatReq), .xlatVaddr(xlatVaddr),
  .xlatRespValid(xlatRespValid), .xlatFault(xlatFault), .memWrEn(memWrEn),
  .memAddr(memAddr), .memReady(memReady), .memErr(memErr),
  .done(done), .fault(fault)
);

// File: tb/blkz_engine_bench.sv
`timescale 1ns/1ps
module blkz_engine_bench;
  localparam int ADDR_W  = 32;
  localparam int EXP_W   = 4;
  localparam int MAX_EXP = 8;
  localparam logic [31:0] PHYS_OFS = 32'h4000_0000;

  logic clk = 0, rst_n = 0;
  logic start = 0, zeroEnable = 0;
  logic [31:0] startAddr = 0;
  logic [EXP_W-1:0] blkExp = 0;
  logic xlatReq, xlatRespValid = 0, xlatFault = 0;
  logic [31:0] xlatVaddr, xlatPaddr, memAddr, memData, faultAddr;
  logic memWrEn, memReady = 0, memErr, done, fault;
  logic [1:0] faultCause;

  always #5 clk = ~clk;

  blkz_engine #(.ADDR_W(ADDR_W), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP)) u_blkz_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .startAddr(startAddr),
    .blkExp(blkExp), .zeroEnable(zeroEnable), .xlatReq(xlatReq),
    .xlatVaddr(xlatVaddr), .xlatRespValid(xlatRespValid), .xlatFault(xlatFault),
    .xlatPaddr(xlatPaddr), .memWrEn(memWrEn), .memAddr(memAddr),
    .memData(memData), .memReady(memReady), .memErr(memErr), .done(done),
    .fault(fault), .faultCause(faultCause), .faultAddr(faultAddr)
  );

  int checks = 0, errors = 0;
  // environment controls
  logic slowMem = 0, failXlat = 0, errArm = 0;
  int errBeat = 0;
  logic [31:0] expPhys = 0;
  // monitor results
  int acc = 0, addrBad = 0, dataBad = 0, doneCnt = 0, faultCnt = 0, xlatAcc = 0;
  logic [1:0] lastCause = 0;
  logic [31:0] lastFAddr = 0, seenVaddr = 0;

  assign xlatPaddr = xlatVaddr + PHYS_OFS;
  assign memErr    = errArm && (acc == errBeat);

  always @(posedge clk) begin
    if (memWrEn && memReady && !memErr) begin
      if (memData != 0) dataBad = dataBad + 1;
      if (memAddr != expPhys + 32'(acc * 4)) addrBad = addrBad + 1;
      acc = acc + 1;
    end
    if (xlatReq && xlatRespValid) begin
      xlatAcc = xlatAcc + 1;
      seenVaddr = xlatVaddr;
    end
    if (done) doneCnt = doneCnt + 1;
    if (fault) begin
      faultCnt = faultCnt + 1;
      lastCause = faultCause;
      lastFAddr = faultAddr;
    end
  end

  always @(negedge clk) begin
    xlatRespValid <= xlatReq && !xlatRespValid;
    xlatFault     <= failXlat;
    memReady      <= slowMem ? !memReady : 1'b1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] alignOf(logic [31:0] a, int e);
    int ee;
    ee = (e < 2) ? 2 : ((e > MAX_EXP) ? MAX_EXP : e);
    return a & ~((32'd1 << ee) - 32'd1);
  endfunction

  task automatic clearMon();
    acc = 0; addrBad = 0; dataBad = 0; doneCnt = 0; faultCnt = 0; xlatAcc = 0;
    lastCause = 0; lastFAddr = 0; seenVaddr = 0;
  endtask

  task automatic launch(logic [31:0] a, int e, logic en);
    @(negedge clk);
    clearMon();
    expPhys = alignOf(a, e) + PHYS_OFS;
    startAddr = a; blkExp = EXP_W'(e); zeroEnable = en; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic waitEnd();
    for (int i = 0; i < 3000 && doneCnt + faultCnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic tReset();
    check("R1 xlatReq", 32'(xlatReq), 0);
    check("R1 memWrEn", 32'(memWrEn), 0);
    check("R1 done/fault", {30'd0, done, fault}, 0);
    check("R1 cause", 32'(faultCause), 0);
  endtask

  task automatic tBasic();
    launch(32'h1234_5677, 6, 1);
    waitEnd();
    check("R2 vaddr", seenVaddr, 32'h1234_5640);
    check("R3 beats", acc, 16);
    check("R3 addr", addrBad, 0);
    check("R3 data", dataBad, 0);
    check("R4 done", doneCnt, 1);
    check("R4 nofault", faultCnt, 0);
  endtask

  task automatic tSlow();
    slowMem = 1;
    launch(32'h0000_0A3F, 4, 1);
    waitEnd();
    slowMem = 0;
    check("R3 slow beats", acc, 4);
    check("R3 slow addr", addrBad, 0);
    check("R4 slow done", doneCnt, 1);
  endtask

  task automatic tClamp();
    launch(32'h0000_1007, 1, 1);
    waitEnd();
    check("R9 low vaddr", seenVaddr, 32'h0000_1004);
    check("R9 low beats", acc, 1);
    launch(32'h0003_07FF, 15, 1);
    waitEnd();
    check("R9 high vaddr", seenVaddr, 32'h0003_0700);
    check("R9 high beats", acc, 64);
    check("R9 high addr", addrBad, 0);
  endtask

  task automatic tXlatFault();
    failXlat = 1;
    launch(32'h0055_0123, 5, 1);
    waitEnd();
    failXlat = 0;
    check("R5 cause", 32'(lastCause), 2);
    check("R5 addr", lastFAddr, 32'h0055_0120);
    check("R5 writes", acc, 0);
    check("R5 done", doneCnt, 0);
  endtask

  task automatic tMemErr(int beat);
    errArm = 1; errBeat = beat;
    launch(32'h0077_00E5, 5, 1);
    waitEnd();
    errArm = 0;
    check("R6 cause", 32'(lastCause), 3);
    check("R6 addr", lastFAddr, 32'h0077_00E0);
    check("R6 writes", acc, beat);
    check("R6/R10 no done", doneCnt, 0);
    check("R10 fault pulse", faultCnt, 1);
  endtask

  task automatic tDisabled();
    launch(32'h0000_2222, 4, 0);
    waitEnd();
    check("R7 cause", 32'(lastCause), 1);
    check("R7 no xlat", xlatAcc, 0);
    check("R7 writes", acc, 0);
  endtask

  task automatic tBusy();
    slowMem = 1;
    launch(32'h0100_0040, 5, 1);
    repeat (6) @(negedge clk);
    startAddr = 32'h0900_0000; blkExp = 3; start = 1;
    @(negedge clk);
    start = 0;
    waitEnd();
    slowMem = 0;
    check("R8 busy beats", acc, 8);
    check("R8 busy addr", addrBad, 0);
    check("R8 busy xlat", xlatAcc, 1);
    check("R8 busy done", doneCnt, 1);
    launch(32'h0200_0008, 2, 1);
    for (int i = 0; i < 100 && !done; i++) @(negedge clk);
    startAddr = 32'h0A00_0000; start = 1;
    @(negedge clk);
    start = 0;
    repeat (6) @(negedge clk);
    check("R8 done-cycle xlat", xlatAcc, 1);
    check("R8 done-cycle done", doneCnt, 1);
    check("R8 done-cycle idle", 32'(xlatReq | memWrEn), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    tReset();
    tBasic();
    tSlow();
    tClamp();
    tXlatFault();
    tMemErr(3);
    tMemErr(7);
    tDisabled();
    tBusy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule